// File: doc/BRIEF.md
# Ternary Match Array with Per-Quadrant Entry Width

This block is a ternary content-addressable search array. Each physical row holds a 68-bit data word and a 68-bit care word, with one care bit for each data bit. A search compares a 68-bit key against every row in parallel. A 68-bit global care vector applies to all rows on top of the per-row care bits. The block returns a hit flag and the physical index of the winning row.

The rows are split into four equal quadrants. A configuration register sets the logical entry width of each quadrant: one row of 68 bits, an aligned pair of 136 bits, or an aligned group of four rows of 272 bits. Tables of different widths can therefore share one array. The search result is registered. Rows and the configuration are written through a simple write port.

`ENTRIES` must be a power of two and at least 16, so that each quadrant holds a whole number of four-row groups.

Top module: `tcam_search`

## Requirements
- R1: A bit position whose global care bit (`gmask_i`) is 0 always matches. A search with `gmask_i` all zero hits physical index 0.
- R2: A bit position whose global care bit is 1 and whose stored care bit is 0 matches for any key bit.
- R3: A bit position whose global care bit and stored care bit are both 1 matches only when the stored data bit equals the key bit.
- R4: In a quadrant whose code is 2'b00 or the reserved 2'b11, each row is its own logical entry. A row hits when all 68 of its positions match.
- R5: Code 2'b01 makes each even row and the odd row after it one 136-bit entry. It hits only when both rows match, and it reports the even index.
- R6: Code 2'b10 makes each group of four rows starting at an index divisible by 4 one 272-bit entry. It hits only when all four rows match, and it reports the first index of the group.
- R7: Configuration bits [2q+1:2q] set quadrant q. Quadrant q covers rows q*ENTRIES/4 to (q+1)*ENTRIES/4-1. Quadrants may use different codes. A write through `cfg_we_i` governs searches issued from the following cycle onward.
- R8: When several logical entries hit, the one with the lowest physical index wins.
- R9: `hit_o` and `idx_o` update on the clock edge that samples `srch_i` and hold their values while no search is issued. On a miss, `hit_o` is 0 and `idx_o` is 0.
- R10: When `wr_en_i` is high, `wr_word_i` is written to row `wr_addr_i`: to the data word when `wr_sel_mask_i` is 0, and to the care word when it is 1. A search in the same cycle sees the contents from before the write.
- R11: Reset clears the configuration to all 2'b00, clears every data and care word to 0, and drives `hit_o` and `idx_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Row write enable |
| wr_sel_mask_i | input | 1 | Write target: 0 selects the data word, 1 selects the care word |
| wr_addr_i | input | $clog2(ENTRIES) | Row address for the write |
| wr_word_i | input | 68 | Word to write |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_i | input | 8 | Width codes, 2 bits per quadrant |
| srch_i | input | 1 | Search strobe |
| key_i | input | 68 | Search key |
| gmask_i | input | 68 | Global care vector |
| hit_o | output | 1 | Registered hit flag |
| idx_o | output | $clog2(ENTRIES) | Registered winning physical index |

## Verification
Assertions check on every cycle that a miss reports index 0 and that the outputs hold between searches. They also check that the winner is the lowest requesting row, that a search with a zero global care vector hits row 0, that data and care writes land in the addressed row, and that a reported index is aligned to the width of its quadrant. Only the bench scenarios can show the correct hit or miss results: a partial pair or group failing, the reserved code acting as single-row mode, the quadrant field positions, and a search seeing the contents from before a write in the same cycle. To show these, the bench compares each search against a reference model computed from the requirements.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned ROW_W = 68;
  localparam int unsigned NQ    = 4;

  typedef enum logic [1:0] {
    WM_68  = 2'b00,
    WM_136 = 2'b01,
    WM_272 = 2'b10,
    WM_RSV = 2'b11
  } width_mode_e;
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int unsigned N  = 32,
  parameter int unsigned W  = 68,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_mask_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [W-1:0]        wr_word_i,
  output logic [N-1:0][W-1:0] data_o,
  output logic [N-1:0][W-1:0] mask_o
);
  for (genvar e = 0; e < N; e++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[e] <= '0;
        mask_o[e] <= '0;
      end else if (wr_en_i && wr_addr_i == AW'(e)) begin
        if (wr_sel_mask_i) mask_o[e] <= wr_word_i;
        else               data_o[e] <= wr_word_i;
      end
    end
  end

  AST_WR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_mask_i) |=> data_o[$past(wr_addr_i)] == $past(wr_word_i)); // R10
  AST_WR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_mask_i) |=> mask_o[$past(wr_addr_i)] == $past(wr_word_i)); // R10
endmodule

// File: rtl/tcam_match.sv
module tcam_match
  import tcam_pkg::*;
#(
  parameter int unsigned N = 32,
  parameter int unsigned W = 68
) (
  input  logic [N-1:0][W-1:0] data_i,
  input  logic [N-1:0][W-1:0] mask_i,
  input  logic [W-1:0]        key_i,
  input  logic [W-1:0]        gmask_i,
  input  logic [2*NQ-1:0]     cfg_i,
  output logic [N-1:0]        hit_o
);
  localparam int unsigned QN = N / NQ;

  logic [N-1:0] row_hit;

  for (genvar e = 0; e < N; e++) begin : g_cmp
    assign row_hit[e] = &(~gmask_i | ~mask_i[e] | ~(data_i[e] ^ key_i));
  end

  for (genvar e = 0; e < N; e++) begin : g_chain
    localparam int unsigned Q = e / QN;
    width_mode_e mode;
    assign mode = width_mode_e'(cfg_i[2*Q +: 2]);
    if (e % 4 == 0) begin : g_lead4
      always_comb begin
        unique case (mode)
          WM_136:  hit_o[e] = &row_hit[e+1:e];
          WM_272:  hit_o[e] = &row_hit[e+3:e];
          default: hit_o[e] = row_hit[e];
        endcase
      end
    end else if (e % 2 == 0) begin : g_lead2
      always_comb begin
        unique case (mode)
          WM_136:  hit_o[e] = &row_hit[e+1:e];
          WM_272:  hit_o[e] = 1'b0;
          default: hit_o[e] = row_hit[e];
        endcase
      end
    end else begin : g_tail
      always_comb begin
        unique case (mode)
          WM_136, WM_272: hit_o[e] = 1'b0;
          default:        hit_o[e] = row_hit[e];
        endcase
      end
    end
  end
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [AW-1:0] idx_o
);
  localparam logic [N-1:0] ONE = N'(1);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = AW'(i);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    if (any_o) begin
      AST_LOWEST_WINS: assert (req_i[idx_o] && (req_i & ((ONE << idx_o) - ONE)) == '0); // R8
    end
  end
endmodule

// File: rtl/tcam_search.sv
module tcam_search
  import tcam_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_mask_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [67:0]      wr_word_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_i,
  input  logic             srch_i,
  input  logic [67:0]      key_i,
  input  logic [67:0]      gmask_i,
  output logic             hit_o,
  output logic [AW-1:0]    idx_o
);
  logic [ENTRIES-1:0][ROW_W-1:0] data_q, mask_q;
  logic [ENTRIES-1:0]            ent_hit;
  logic [2*NQ-1:0]               cfg_q;
  logic                          any_hit;
  logic [AW-1:0]                 win_idx;

  tcam_store #(.N(ENTRIES), .W(ROW_W), .AW(AW)) i_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_mask_i, .wr_addr_i, .wr_word_i,
    .data_o(data_q), .mask_o(mask_q)
  );

  tcam_match #(.N(ENTRIES), .W(ROW_W)) i_match (
    .data_i(data_q), .mask_i(mask_q), .key_i, .gmask_i,
    .cfg_i(cfg_q), .hit_o(ent_hit)
  );

  tcam_prio #(.N(ENTRIES), .AW(AW)) i_prio (
    .req_i(ent_hit), .any_o(any_hit), .idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0;
      idx_o <= '0;
    end else if (srch_i) begin
      hit_o <= any_hit;
      idx_o <= any_hit ? win_idx : '0;
    end
  end

  AST_MISS_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> idx_o == '0); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_i |=> $stable(hit_o) && $stable(idx_o)); // R9
  AST_GMASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_i && gmask_i == '0) |=> hit_o && idx_o == '0); // R1
  AST_PAIR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(srch_i) && hit_o &&
     2'($past(cfg_q) >> {idx_o[AW-1 -: 2], 1'b0}) == WM_136) |-> !idx_o[0]); // R5
  AST_QUAD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(srch_i) && hit_o &&
     2'($past(cfg_q) >> {idx_o[AW-1 -: 2], 1'b0}) == WM_272) |-> idx_o[1:0] == 2'b00); // R6
endmodule

// File: tb/test_tcam_search.sv
module test_tcam_search;
  localparam int N  = 32;
  localparam int AW = $clog2(N);
  localparam int QN = N / 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0, wr_sel = 0, cfg_we = 0, srch = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [67:0]   wr_word = '0, key = '0, gm = '0;
  logic [7:0]    cfg = '0;
  logic          hit;
  logic [AW-1:0] idx;

  int tests = 0, fails = 0;

  logic [67:0] m_data [N];
  logic [67:0] m_mask [N];
  logic [7:0]  m_cfg;

  always #4 clk = ~clk;

  tcam_search #(.ENTRIES(N)) i_tcam_search (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_mask_i(wr_sel),
    .wr_addr_i(wr_addr), .wr_word_i(wr_word), .cfg_we_i(cfg_we), .cfg_i(cfg),
    .srch_i(srch), .key_i(key), .gmask_i(gm), .hit_o(hit), .idx_o(idx)
  );

  function automatic logic [AW:0] model(logic [67:0] k, logic [67:0] g);
    logic [N-1:0] rm;
    for (int e = 0; e < N; e++) rm[e] = &(~g | ~m_mask[e] | ~(m_data[e] ^ k));
    for (int e = 0; e < N; e++) begin
      logic [1:0] md;
      logic ok;
      md = m_cfg[2*(e/QN) +: 2];
      if (md == 2'b01)      ok = (e % 2 == 0) && rm[e] && rm[e+1];
      else if (md == 2'b10) ok = (e % 4 == 0) && rm[e] && rm[e+1] && rm[e+2] && rm[e+3];
      else                  ok = rm[e];
      if (ok) return {1'b1, AW'(e)};
    end
    return '0;
  endfunction

  function automatic logic [67:0] rnd68();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(string tag, logic [AW:0] got, logic [AW:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got hit=%0b idx=%0d, expected hit=%0b idx=%0d",
               tag, got[AW], got[AW-1:0], exp[AW], exp[AW-1:0]);
    end
  endtask

  task automatic wr(int a, bit sel, logic [67:0] v);
    wr_en = 1; wr_sel = sel; wr_addr = AW'(a); wr_word = v;
    @(negedge clk);
    wr_en = 0;
    if (sel) m_mask[a] = v; else m_data[a] = v;
  endtask

  task automatic set_cfg(logic [7:0] c);
    cfg_we = 1; cfg = c;
    @(negedge clk);
    cfg_we = 0; m_cfg = c;
  endtask

  task automatic search(string tag, logic [67:0] k, logic [67:0] g);
    logic [AW:0] exp;
    exp = model(k, g);
    srch = 1; key = k; gm = g;
    @(negedge clk);
    srch = 0;
    check(tag, {hit, idx}, exp);
  endtask

  function automatic logic [67:0] pat(int e);
    return {4'h0, 32'hA5A5_0000 | 32'(e), 32'(e)};
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [AW:0] held;
    logic [AW:0] exp;
    void'($urandom(32'd7));
    for (int e = 0; e < N; e++) begin m_data[e] = '0; m_mask[e] = '0; end
    m_cfg = '0;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {hit, idx}, '0);
    rst_n = 1;
    @(negedge clk);
    search("R11 reset contents all dont-care", rnd68(), '1);

    for (int e = 0; e < N; e++) begin wr(e, 0, pat(e)); wr(e, 1, '1); end
    search("R3 exact match", pat(5), '1);
    search("R3 single bit mismatch miss", pat(5) ^ 68'h1, '1);
    search("R1 global care clears bit 0", pat(5) ^ 68'h1, ~68'h1);
    search("R1 zero global care hits 0", rnd68(), '0);
    wr(9, 1, ~68'hF);
    search("R2 stored dont-care low nibble", {pat(9)[67:4], 4'h6}, '1);
    wr(12, 0, pat(20));
    search("R8 lowest duplicate wins", pat(20), '1);

    set_cfg(8'h01);
    search("R5 pair with odd half failing", pat(2), '1);
    wr(3, 1, '0);
    search("R5 pair hit reports even index", pat(2), '1);
    search("R5 odd row alone cannot hit", pat(3), '1);
    wr(0, 1, '0); wr(1, 1, '0);
    set_cfg(8'h02);
    search("R6 group of four hits at 0", pat(2), '1);
    set_cfg(8'h0E);
    search("R4 reserved code acts as single row", pat(10), '1);
    for (int e = 0; e < 4; e++) wr(e, 1, '1);
    set_cfg(8'h04);
    search("R7 quadrant 1 paired field position", pat(10), '1);
    set_cfg(8'h40);
    search("R7 quadrant 3 field leaves quadrant 1", pat(10), '1);

    // R7: a search in the cycle of a configuration write uses the old codes
    exp = model(pat(10), '1);
    cfg_we = 1; cfg = 8'h04; srch = 1; key = pat(10); gm = '1;
    @(negedge clk);
    cfg_we = 0; srch = 0; m_cfg = 8'h04;
    check("R7 cfg write not seen same cycle", {hit, idx}, exp);
    set_cfg(8'h00);

    // R10: a search in the cycle of a write sees the old contents
    exp = model(pat(10), '1);
    wr_en = 1; wr_sel = 0; wr_addr = AW'(10); wr_word = ~pat(10);
    srch = 1; key = pat(10); gm = '1;
    @(negedge clk);
    wr_en = 0; srch = 0; m_data[10] = ~pat(10);
    check("R10 same-cycle search sees old row", {hit, idx}, exp);
    search("R10 write visible next search", pat(10), '1);

    held = {hit, idx};
    key = rnd68();
    repeat (3) @(negedge clk);
    check("R9 outputs hold without search", {hit, idx}, held);
    search("R9 miss clears index", ~pat(7), '1);

    for (int it = 0; it < 600; it++) begin
      int op;
      int e;
      op = int'($urandom() % 10);
      e  = int'($urandom() % N);
      if (op < 3) wr(e, 0, rnd68());
      else if (op < 5) wr(e, 1, rnd68() & rnd68() & rnd68());
      else if (op == 5) set_cfg(8'($urandom()));
      else begin
        logic [67:0] g;
        g = ($urandom() % 4 == 0) ? (rnd68() | rnd68()) : '1;
        search("R4 R5 R6 R8 random search",
               ($urandom() % 3 == 0) ? (m_data[e] ^ (68'h1 << ($urandom() % 68))) : m_data[e], g);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule